// File: doc/BRIEF.md
# Random Memory Tag Generator

This block picks a 4-bit allocation tag for a pointer and returns the pointer with that tag written into its tag field (bits 59:56 by default). It serves two request kinds. A random request draws a 4-bit step count from a 16-bit linear feedback shift register. It then walks forward from the tag chosen last time, skipping every tag the exclusion mask forbids. An add request takes its start tag from the pointer itself and its step count from the request. It adds a signed offset to the address, and it walks the same way under the control mask alone.

The block keeps a small state register holding the LFSR seed and the last random tag. A random request rewrites both when it completes. That state can also be loaded directly while the block is idle. Each request runs as a short multi-cycle sequence through three states. IDLE waits for a request or a load. An accepted random request moves IDLE→STEP, and an accepted add request moves IDLE→WALK. STEP performs one LFSR step per cycle and moves STEP→WALK after the fourth. WALK advances the tag by one allowed position per cycle, or resolves an offset of zero in one cycle, and moves WALK→IDLE as it raises `done` with the result.

Top module: `rand_tag_unit`

## Requirements
- R1: When exclusion mask bit k is 1, tag k is never returned, except under R2.
- R2: When the exclusion mask in use is 16'hFFFF, the returned tag is 0 whatever the start tag and step count.
- R3: One LFSR step forms f = s[5]^s[3]^s[2]^s[0] and sets s to {f, s[15:1]}.
- R4: A random request applies exactly four LFSR steps, and the f of step i (i = 0..3) becomes bit i of the step count.
- R5: With a step count of 0, the start tag is returned if allowed; otherwise the first allowed tag above it, counting modulo 16.
- R6: With a step count n > 0, the tag moves n times, each time to the next allowed tag strictly after the current one modulo 16. So a single allowed tag equal to the start is returned after a full wrap.
- R7: A random request (req_kind = 0) uses the mask req_mask | ctl_mask and starts from the stored tag. It returns req_ptr with bits 59:56 replaced by the chosen tag.
- R8: When a random request completes, the stored tag becomes the chosen tag and the stored seed becomes the seed after the four steps. An add request leaves both unchanged. In IDLE, st_load writes both, and a request in the same cycle is dropped.
- R9: An add request (req_kind = 1) starts from req_ptr[59:56], uses step count req_tag_step and mask ctl_mask only. It returns (req_ptr + sign-extended req_delta) with bits 59:56 then replaced by the chosen tag.
- R10: If the stored seed is 0 and ctl_rand_en is 1, a random request first replaces the seed with 16'hACE1. With ctl_rand_en at 0, a zero seed stays zero and yields a step count of 0.
- R11: Let w = 1 if the mask is 16'hFFFF, else max(1, step count). `done` rises 4+w clock edges after a random request is accepted and w edges after an add request, for one cycle. `busy` is high in between. Requests seen while busy are ignored.
- R12: After reset, busy and done are 0, the stored seed is 16'h0000 and the stored tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted in IDLE |
| req_kind | input | 1 | 0 random request, 1 add request |
| req_ptr | input | 64 | Source pointer |
| req_mask | input | 16 | Operand exclusion mask (random request only) |
| req_tag_step | input | 4 | Step count for an add request |
| req_delta | input | 16 | Signed address offset for an add request |
| ctl_mask | input | 16 | Control exclusion mask |
| ctl_rand_en | input | 1 | Allow replacement of a zero seed |
| st_load | input | 1 | Load stored seed and tag (IDLE only) |
| st_load_seed | input | 16 | Seed value to load |
| st_load_tag | input | 4 | Tag value to load |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| res_ptr | output | 64 | Pointer carrying the chosen tag |
| res_tag | output | 4 | Chosen tag |
| state_seed | output | 16 | Stored LFSR seed |
| state_tag | output | 4 | Stored last random tag |

## Verification
The bench targets wraparound from tag 15 to tag 0 past excluded entries. It also covers a mask leaving exactly one allowed tag, which a design that stops after one probe would miss, and a full mask, which a design that loops forever or returns the start tag would get wrong. It checks the zero seed with and without replacement enabled, and an address offset whose carry runs into the tag field, which must then be overwritten and not leak into the returned tag. Requests and mask changes while busy, and a load that collides with a request, expose designs that re-capture inputs mid-flight or accept work outside IDLE. Done and busy are compared every cycle, so an off-by-one in the number of steps or moves shows up as timing errors.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_WALK = 2'd2
    } rtg_state_e;

    typedef enum logic {
        KIND_RANDOM = 1'b0,
        KIND_ADD    = 1'b1
    } rtg_kind_e;

endpackage

// File: rtl/rtg_lfsr_step.sv
module rtg_lfsr_step #(
    parameter int SEED_W = 16
) (
    input  logic [SEED_W-1:0] seed_in,
    output logic [SEED_W-1:0] seed_out,
    output logic              fb
);
    // Feedback taps 5, 3, 2, 0; shift right, feedback enters at the top.
    always_comb begin
        fb       = seed_in[5] ^ seed_in[3] ^ seed_in[2] ^ seed_in[0];
        seed_out = {fb, seed_in[SEED_W-1:1]};
    end
endmodule

// File: rtl/rtg_tag_pick.sv
module rtg_tag_pick #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0]        cur,
    input  logic [(1<<TAG_W)-1:0]   excl,
    input  logic                    incl,
    output logic [TAG_W-1:0]        pick
);
    localparam int NT = 1 << TAG_W;

    logic [TAG_W-1:0] cand [NT];
    logic [NT-1:0]    ok;

    // Probe j looks at cur+j (inclusive) or cur+j+1 (strictly after).
    for (genvar j = 0; j < NT; j++) begin : g_probe
        assign cand[j] = cur + TAG_W'(j) + TAG_W'(!incl);
        assign ok[j]   = !excl[cand[j]];
    end

    always_comb begin
        pick = '0;
        for (int j = NT - 1; j >= 0; j--) begin
            if (ok[j]) pick = cand[j];
        end
    end
endmodule

// File: rtl/rtg_ptr_compose.sv
module rtg_ptr_compose #(
    parameter int PTR_W   = 64,
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56
) (
    input  logic [PTR_W-1:0] base,
    input  logic [TAG_W-1:0] tag,
    output logic [PTR_W-1:0] ptr_out
);
    always_comb begin
        ptr_out                  = base;
        ptr_out[TAG_LSB +: TAG_W] = tag;
    end
endmodule

// File: rtl/rand_tag_unit.sv
module rand_tag_unit
    import rtg_pkg::*;
#(
    parameter int              PTR_W      = 64,
    parameter int              TAG_W      = 4,
    parameter int              TAG_LSB    = 56,
    parameter int              SEED_W     = 16,
    parameter int              DELTA_W    = 16,
    parameter logic [15:0]     FILL_SEED  = 16'hACE1,
    parameter logic [15:0]     RESET_SEED = 16'h0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_kind,
    input  logic [PTR_W-1:0]      req_ptr,
    input  logic [(1<<TAG_W)-1:0] req_mask,
    input  logic [TAG_W-1:0]      req_tag_step,
    input  logic [DELTA_W-1:0]    req_delta,
    input  logic [(1<<TAG_W)-1:0] ctl_mask,
    input  logic                  ctl_rand_en,
    input  logic                  st_load,
    input  logic [SEED_W-1:0]     st_load_seed,
    input  logic [TAG_W-1:0]      st_load_tag,
    output logic                  busy,
    output logic                  done,
    output logic [PTR_W-1:0]      res_ptr,
    output logic [TAG_W-1:0]      res_tag,
    output logic [SEED_W-1:0]     state_seed,
    output logic [TAG_W-1:0]      state_tag
);
    localparam int NT     = 1 << TAG_W;
    localparam int STEPS  = TAG_W;
    localparam int SCNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    rtg_state_e            state_q, state_d;
    rtg_kind_e             kind_q;
    logic [NT-1:0]         excl_q;
    logic [TAG_W-1:0]      cur_q;
    logic [TAG_W-1:0]      rem_q;
    logic [SEED_W-1:0]     seed_w_q;
    logic [SCNT_W-1:0]     stepn_q;
    logic [PTR_W-1:0]      ptr_q;
    logic [SEED_W-1:0]     st_seed_q;
    logic [TAG_W-1:0]      st_tag_q;
    logic                  done_q;
    logic [PTR_W-1:0]      res_ptr_q;
    logic [TAG_W-1:0]      res_tag_q;

    logic                  accept;
    logic [SEED_W-1:0]     lfsr_next;
    logic                  lfsr_fb;
    logic [TAG_W-1:0]      pick_tag;
    logic                  all_ones;
    logic                  walk_last;
    logic [TAG_W-1:0]      fin_tag;
    logic [PTR_W-1:0]      comp_ptr;
    logic [PTR_W-1:0]      delta_ext;

    rtg_lfsr_step #(.SEED_W(SEED_W)) u_lfsr (
        .seed_in  (seed_w_q),
        .seed_out (lfsr_next),
        .fb       (lfsr_fb)
    );

    rtg_tag_pick #(.TAG_W(TAG_W)) u_pick (
        .cur  (cur_q),
        .excl (excl_q),
        .incl (rem_q == '0),
        .pick (pick_tag)
    );

    rtg_ptr_compose #(.PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)) u_comp (
        .base    (ptr_q),
        .tag     (fin_tag),
        .ptr_out (comp_ptr)
    );

    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid && !st_load;
        all_ones  = &excl_q;
        walk_last = all_ones || (rem_q <= TAG_W'(1));
        fin_tag   = all_ones ? '0 : pick_tag;
        delta_ext = {{(PTR_W-DELTA_W){req_delta[DELTA_W-1]}}, req_delta};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = (rtg_kind_e'(req_kind) == KIND_ADD) ? ST_WALK : ST_STEP;
            end
            ST_STEP: begin
                if (stepn_q == SCNT_W'(STEPS - 1)) state_d = ST_WALK;
            end
            ST_WALK: begin
                if (walk_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and stored state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= KIND_RANDOM;
            excl_q    <= '0;
            cur_q     <= '0;
            rem_q     <= '0;
            seed_w_q  <= '0;
            stepn_q   <= '0;
            ptr_q     <= '0;
            st_seed_q <= RESET_SEED[SEED_W-1:0];
            st_tag_q  <= '0;
            done_q    <= 1'b0;
            res_ptr_q <= '0;
            res_tag_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (st_load) begin
                        st_seed_q <= st_load_seed;
                        st_tag_q  <= st_load_tag;
                    end else if (accept) begin
                        kind_q <= rtg_kind_e'(req_kind);
                        if (rtg_kind_e'(req_kind) == KIND_RANDOM) begin
                            excl_q   <= req_mask | ctl_mask;
                            cur_q    <= st_tag_q;
                            rem_q    <= '0;
                            stepn_q  <= '0;
                            seed_w_q <= ((st_seed_q == '0) && ctl_rand_en)
                                        ? FILL_SEED[SEED_W-1:0] : st_seed_q;
                            ptr_q    <= req_ptr;
                        end else begin
                            excl_q <= ctl_mask;
                            cur_q  <= req_ptr[TAG_LSB +: TAG_W];
                            rem_q  <= req_tag_step;
                            ptr_q  <= req_ptr + delta_ext;
                        end
                    end
                end
                ST_STEP: begin
                    seed_w_q       <= lfsr_next;
                    rem_q[stepn_q] <= lfsr_fb;
                    stepn_q        <= stepn_q + SCNT_W'(1);
                end
                ST_WALK: begin
                    if (walk_last) begin
                        res_tag_q <= fin_tag;
                        res_ptr_q <= comp_ptr;
                        done_q    <= 1'b1;
                        if (kind_q == KIND_RANDOM) begin
                            st_tag_q  <= fin_tag;
                            st_seed_q <= seed_w_q;
                        end
                    end else begin
                        cur_q <= pick_tag;
                        rem_q <= rem_q - TAG_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        res_ptr    = res_ptr_q;
        res_tag    = res_tag_q;
        state_seed = st_seed_q;
        state_tag  = st_tag_q;
    end
endmodule

// File: rtl/rand_tag_unit_chk.sv
module rand_tag_unit_chk #(
    parameter int PTR_W   = 64,
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56,
    parameter int SEED_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  done,
    input logic                  busy,
    input logic                  req_valid,
    input logic                  st_load,
    input logic [TAG_W-1:0]      res_tag,
    input logic [PTR_W-1:0]      res_ptr,
    input logic [(1<<TAG_W)-1:0] excl,
    input logic [SEED_W-1:0]     st_seed
);
    a_r1_never_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(&excl)) |-> !excl[res_tag]);

    a_r2_full_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&excl)) |-> (res_tag == '0));

    a_r7_tag_in_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_ptr[TAG_LSB +: TAG_W] == res_tag));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_seed_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid && !st_load) |=> $stable(st_seed));
endmodule

bind rand_tag_unit rand_tag_unit_chk #(
    .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB), .SEED_W(SEED_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .busy      (busy),
    .req_valid (req_valid),
    .st_load   (st_load),
    .res_tag   (res_tag),
    .res_ptr   (res_ptr),
    .excl      (excl_q),
    .st_seed   (state_seed)
);

// File: tb/sim_rand_tag_unit.sv
module sim_rand_tag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [15:0] req_mask = '0;
    logic [3:0]  req_tag_step = '0;
    logic [15:0] req_delta = '0;
    logic [15:0] ctl_mask = '0;
    logic        ctl_rand_en = 1'b0;
    logic        st_load = 1'b0;
    logic [15:0] st_load_seed = '0;
    logic [3:0]  st_load_tag = '0;
    logic        busy, done;
    logic [63:0] res_ptr;
    logic [3:0]  res_tag;
    logic [15:0] state_seed;
    logic [3:0]  state_tag;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_seed = 16'h0000;
    logic [3:0]  m_tag = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rand_tag_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ptr(req_ptr), .req_mask(req_mask), .req_tag_step(req_tag_step),
        .req_delta(req_delta), .ctl_mask(ctl_mask), .ctl_rand_en(ctl_rand_en),
        .st_load(st_load), .st_load_seed(st_load_seed), .st_load_tag(st_load_tag),
        .busy(busy), .done(done), .res_ptr(res_ptr), .res_tag(res_tag),
        .state_seed(state_seed), .state_tag(state_tag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] choose(input logic [3:0] start, input logic [3:0] off,
                                          input logic [15:0] m);
        logic [3:0] t;
        if (m == 16'hFFFF) return 4'h0;
        t = start;
        if (off == 0) begin
            while (m[t]) t = t + 4'h1;
        end else begin
            for (int n = 0; n < int'(off); n++) begin
                t = t + 4'h1;
                while (m[t]) t = t + 4'h1;
            end
        end
        return t;
    endfunction

    function automatic logic [63:0] put_tag(input logic [63:0] p, input logic [3:0] t);
        logic [63:0] r;
        r = p;
        r[59:56] = t;
        return r;
    endfunction

    // One request, compared cycle by cycle against the behavioural model.
    task automatic run_req(input string req, input logic kind, input logic [63:0] ptr,
                           input logic [15:0] opmask, input logic [3:0] step,
                           input logic [15:0] delta, input logic [15:0] cmask,
                           input logic ren, input bit intrude);
        logic [15:0] m, s;
        logic [3:0]  off, start, t;
        logic [63:0] eptr;
        logic        fb;
        int          w, lat;
        if (kind == 1'b0) begin
            m = opmask | cmask;
            start = m_tag;
            s = (m_seed == 16'h0 && ren) ? 16'hACE1 : m_seed;
            off = 4'h0;
            for (int i = 0; i < 4; i++) begin
                fb = s[5] ^ s[3] ^ s[2] ^ s[0];
                s = {fb, s[15:1]};
                off[i] = fb;
            end
            t = choose(start, off, m);
            eptr = put_tag(ptr, t);
        end else begin
            m = cmask;
            start = ptr[59:56];
            off = step;
            s = m_seed;
            t = choose(start, off, m);
            eptr = put_tag(ptr + {{48{delta[15]}}, delta}, t);
        end
        w = (m == 16'hFFFF) ? 1 : ((off == 0) ? 1 : int'(off));
        lat = (kind == 1'b0) ? 4 + w : w;

        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_ptr = ptr; req_mask = opmask;
        req_tag_step = step; req_delta = delta; ctl_mask = cmask; ctl_rand_en = ren;
        @(negedge clk);
        chk({req, " R11 busy after accept"}, 64'(busy), 64'd1);
        if (intrude) begin
            req_kind = ~kind; req_ptr = ~ptr; req_mask = ~opmask;
            req_tag_step = step + 4'h5; ctl_mask = ~cmask; ctl_rand_en = ~ren;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            chk({req, " R11 done timing"}, 64'(done), 64'(k == lat));
            chk({req, " R11 busy timing"}, 64'(busy), 64'(k < lat));
        end
        req_valid = 1'b0;
        if (kind == 1'b0) begin
            m_tag = t;
            m_seed = s;
        end
        chk({req, " R7 R9 result tag"}, 64'(res_tag), 64'(t));
        chk({req, " R7 R9 result ptr"}, res_ptr, eptr);
        chk({req, " R8 stored seed"}, 64'(state_seed), 64'(m_seed));
        chk({req, " R8 stored tag"}, 64'(state_tag), 64'(m_tag));
        @(negedge clk);
        chk({req, " R11 done single pulse"}, 64'(done), 64'd0);
        chk({req, " R11 ignored while busy"}, 64'(busy), 64'd0);
    endtask

    // Load of stored state, with a colliding request that must be dropped.
    task automatic load_state(input logic [15:0] s, input logic [3:0] t);
        @(negedge clk);
        st_load = 1'b1; st_load_seed = s; st_load_tag = t;
        req_valid = 1'b1; req_kind = 1'b1; req_tag_step = 4'h3;
        @(negedge clk);
        st_load = 1'b0; req_valid = 1'b0;
        m_seed = s; m_tag = t;
        chk("R8 load seed", 64'(state_seed), 64'(s));
        chk("R8 load tag", 64'(state_tag), 64'(t));
        chk("R8 request dropped on load", 64'(busy), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset busy", 64'(busy), 64'd0);
        chk("R12 reset done", 64'(done), 64'd0);
        chk("R12 reset seed", 64'(state_seed), 64'h0);
        chk("R12 reset tag", 64'(state_tag), 64'h0);

        // R10: zero seed replaced when enabled
        run_req("R10 fill seed", 1'b0, 64'h0123_4567_89AB_CDEF, 16'h0000, 4'h0, 16'h0, 16'h0000, 1'b1, 0);
        // R10/R5: zero seed kept when disabled, step 0, start excluded
        load_state(16'h0000, 4'h5);
        run_req("R10 R5 zero seed kept", 1'b0, 64'h00AA_0000_0000_1000, 16'h0020, 4'h0, 16'h0, 16'h0040, 1'b0, 0);
        // R2: full mask gives tag 0, seed still advances
        load_state(16'h1234, 4'h9);
        run_req("R2 R4 full mask random", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFF00, 4'h0, 16'h0, 16'h00FF, 1'b1, 0);
        // R3/R4/R1: several seeds and masks
        for (int i = 0; i < 12; i++) begin
            load_state(16'h1D2B * 16'(i + 1) ^ 16'h5A5A, 4'(i * 5));
            run_req("R1 R3 R4 R7 random sweep", 1'b0, 64'h0F00_0000_1234_0000 + 64'(i),
                    16'h8001 << (i % 4), 4'h0, 16'h0, 16'(i * 16'h0111) & 16'h7E7E, 1'b1, 0);
        end
        // back-to-back random without reload
        for (int i = 0; i < 6; i++)
            run_req("R3 R8 chained random", 1'b0, 64'h1000_0000_0000_0040, 16'h0000, 4'h0, 16'h0,
                    16'(16'h0003 << i), 1'b1, 0);
        // R9/R5: add, step 0, start allowed
        run_req("R9 R5 add step0 allowed", 1'b1, 64'h0700_0000_0000_0100, 16'hFFFF, 4'h0, 16'h0010, 16'h0000, 1'b1, 0);
        // R5: start 15 excluded, wrap to 0
        run_req("R5 wrap from 15", 1'b1, 64'h0F00_0000_0000_0000, 16'h0, 4'h0, 16'h0000, 16'h8000, 1'b1, 0);
        // R6: step 3 with skips and wrap
        run_req("R6 step3 skips", 1'b1, 64'h0D00_0000_0000_2000, 16'h0, 4'h3, 16'hFFF0, 16'h4003, 1'b1, 0);
        // R6: only the start tag allowed, full wrap each move
        run_req("R6 single allowed", 1'b1, 64'h0600_0000_0000_0000, 16'h0, 4'h4, 16'h0001, 16'hFFBF, 1'b1, 0);
        // R2: add with full control mask
        run_req("R2 add full mask", 1'b1, 64'h0300_0000_0000_0000, 16'h0, 4'h7, 16'h0000, 16'hFFFF, 1'b1, 0);
        // R9: carry from address into tag field is overwritten
        run_req("R9 carry into tag", 1'b1, 64'h00FF_FFFF_FFFF_FFFF, 16'h0, 4'h1, 16'h0001, 16'h0000, 1'b1, 0);
        // R9: negative delta with borrow
        run_req("R9 negative delta", 1'b1, 64'h2A00_0000_0000_0004, 16'h0, 4'hF, 16'hFFF0, 16'h1248, 1'b1, 0);
        // R11: requests held during busy are ignored (add and random)
        run_req("R11 intrude add", 1'b1, 64'h0100_0000_0000_0800, 16'h0, 4'h2, 16'h0020, 16'h0004, 1'b1, 1);
        run_req("R11 intrude random", 1'b0, 64'h0500_0000_0000_0000, 16'h00F0, 4'h0, 16'h0, 16'h0000, 1'b1, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule